// File: doc/BRIEF.md
# Link Sleep and Self-Refresh Resume Sequencer

This block controls the power state of a video bridge's output link while the attached display holds its own image in panel self-refresh. When the suspend request pin is asserted, the sequencer powers down the PLL, the link transmitter and the video input receiver. The main-link mode code is forced to Off and video transmission stops. Configuration state and pending interrupt status are kept through the sleep. The suspend pin is asynchronous to the sequencer clock. It is brought in through a two-stage synchronizer. The sequencer clock may be a dedicated reference or a divided-down input video clock. In either case it must run around each edge of the request, and it may stop while the block sleeps.

Leaving sleep happens in three gated steps. First the block waits for the PLL to report lock. It then raises the link into one of two operating modes, chosen by a training-mode bit. Finally it releases video at the first vertical-sync-start pulse from the input. That release is either automatic, or held until software has set a stream-enable bit. A hot-plug interrupt event is latched as sticky status. The status drives the interrupt line through two enables. A PWM drive enable follows its configuration bit and is unaffected by sleep.

Top module: `link_sleep_seq`

## Requirements
- R1: After synchronous reset the block is in the PLL-wait step: all three power-down outputs are 0, `ml_mode` is 2'b00 (Off), `video_tx_en` is 0 and `irq` is 0.
- R2: The suspend request passes through two flops. A level that is stable before rising edge k first affects the outputs after rising edge k+2.
- R3: While suspended, `pll_pd`, `tx_pd` and `rx_pd` are all 1, `ml_mode` is 2'b00 and `video_tx_en` is 0.
- R4: After the request is released, `ml_mode` stays 2'b00 until the cycle after `pll_locked` is seen high. It then becomes 2'b01 (Normal) if `cfg_semi_auto` was 0 at that edge, or 2'b10 (Semi-Auto) if it was 1. The choice holds until the next suspend.
- R5: With `cfg_auto_resume` = 1, `video_tx_en` rises one cycle after the first `vss_pulse` seen while the link mode is up.
- R6: With `cfg_auto_resume` = 0, a `vss_pulse` seen while `cfg_stream_en` = 0 is ignored. Video starts one cycle after a `vss_pulse` seen with `cfg_stream_en` = 1.
- R7: A `hpd_irq_evt` sets a sticky status bit, and `irq_clr` clears it; an event in the same cycle as a clear wins. `irq` equals that status ANDed with `cfg_irq_en` and `cfg_hpd_irq_en`.
- R8: Entering or leaving suspend does not clear the interrupt status.
- R9: `pwm_oe` equals `cfg_pwm_active` in every state, including suspend.
- R10: A suspend request takes effect from the PLL-wait, link-up and video steps alike, and drops video at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer reference clock |
| rst | input | 1 | Synchronous active-high reset |
| susp_req | input | 1 | Asynchronous suspend request pin |
| pll_locked | input | 1 | PLL lock indication |
| cfg_semi_auto | input | 1 | Training-mode select: 1 picks Semi-Auto, 0 Normal |
| cfg_auto_resume | input | 1 | Resume video automatically at first vertical sync start |
| cfg_stream_en | input | 1 | Software stream enable |
| vss_pulse | input | 1 | Vertical-sync-start pulse from the video input |
| hpd_irq_evt | input | 1 | Hot-plug interrupt event |
| irq_clr | input | 1 | Write-one-to-clear strobe for the hot-plug status |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_hpd_irq_en | input | 1 | Hot-plug interrupt enable |
| cfg_pwm_active | input | 1 | PWM pin configured as an active output |
| pll_pd | output | 1 | PLL power-down |
| tx_pd | output | 1 | Link transmitter power-down |
| rx_pd | output | 1 | Video input receiver power-down |
| ml_mode | output | 2 | Main-link mode: 00 Off, 01 Normal, 10 Semi-Auto |
| video_tx_en | output | 1 | Video transmission enable |
| irq | output | 1 | Interrupt line |
| pwm_oe | output | 1 | PWM pin drive enable |

## Verification
The bench targets the latency of the suspend synchronizer. A design with one stage too few or too many would power down a cycle early or late. It checks that a vertical sync start arriving while the stream enable is low is dropped. A design that ignored the gate would start video early, and one that latched the pulse would start video later without a fresh sync. It changes the training bit after lock, to catch a mode that is not captured at lock. It also raises a hot-plug event in the same cycle as a clear and across a suspend. A design that gave the clear priority, or reset the status on sleep, would lose the interrupt.

// File: rtl/lss_pkg.sv
package lss_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ML_OFF    = 2'b00,
        ML_NORMAL = 2'b01,
        ML_SEMI   = 2'b10
    } ml_mode_e;

    typedef enum logic [1:0] {
        ST_SUSP,
        ST_PLL_WAIT,
        ST_LINK,
        ST_VIDEO
    } seq_state_e;

    typedef struct packed {
        logic pll;
        logic tx;
        logic rx;
    } pwr_dn_t;

    function automatic ml_mode_e pick_mode(input logic semi);
        return semi ? ML_SEMI : ML_NORMAL;
    endfunction

    function automatic logic video_gate(input logic auto_resume, input logic stream_en);
        return auto_resume | stream_en;
    endfunction

endpackage

// File: rtl/lss_sync.sv
module lss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lss_hpd_irq.sv
module lss_hpd_irq (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    input  logic glb_en,
    input  logic hpd_en,
    output logic irq
);
    logic status;

    always_ff @(posedge clk) begin
        if (rst)      status <= 1'b0;
        else if (evt) status <= 1'b1;
        else if (clr) status <= 1'b0;
    end

    assign irq = status & glb_en & hpd_en;

    // R7: a clear with no event empties the status
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !irq);
    // R7: an event always leaves the status set
    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt && glb_en && hpd_en) |=> (irq || !glb_en || !hpd_en));
endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
    import lss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      susp_s,
    input  logic      pll_locked,
    input  logic      cfg_semi_auto,
    input  logic      cfg_auto_resume,
    input  logic      cfg_stream_en,
    input  logic      vss_pulse,
    output pwr_dn_t   pd,
    output ml_mode_e  mode,
    output logic      video_en
);
    seq_state_e state, nxt;
    ml_mode_e   link_mode;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SUSP:     if (!susp_s) nxt = ST_PLL_WAIT;
            ST_PLL_WAIT: if (susp_s) nxt = ST_SUSP;
                         else if (pll_locked) nxt = ST_LINK;
            ST_LINK:     if (susp_s) nxt = ST_SUSP;
                         else if (vss_pulse && video_gate(cfg_auto_resume, cfg_stream_en))
                             nxt = ST_VIDEO;
            ST_VIDEO:    if (susp_s) nxt = ST_SUSP;
            default:     nxt = ST_PLL_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PLL_WAIT;
            link_mode <= ML_NORMAL;
        end else begin
            state <= nxt;
            if (state == ST_PLL_WAIT && nxt == ST_LINK)
                link_mode <= pick_mode(cfg_semi_auto);
        end
    end

    assign pd.pll   = (state == ST_SUSP);
    assign pd.tx    = (state == ST_SUSP);
    assign pd.rx    = (state == ST_SUSP);
    assign mode     = (state == ST_LINK || state == ST_VIDEO) ? link_mode : ML_OFF;
    assign video_en = (state == ST_VIDEO);

    // R3: powered-down link carries no mode and no video
    a_r3_off_when_down: assert property (@(posedge clk) disable iff (rst)
        pd.pll |-> (mode == ML_OFF && !video_en));
    // R4: the mode leaves Off only after lock was seen
    a_r4_lock_first: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == ML_OFF && mode != ML_OFF) |-> $past(pll_locked));
    // R5: video starts only after a vertical sync start
    a_r5_video_on_vss: assert property (@(posedge clk) disable iff (rst)
        $rose(video_en) |-> ($past(vss_pulse) && mode != ML_OFF));
    // R10: a synchronized request powers down on the next edge
    a_r10_enter_susp: assert property (@(posedge clk) disable iff (rst)
        susp_s |=> (pd.pll && !video_en));
endmodule

// File: rtl/link_sleep_seq.sv
module link_sleep_seq
    import lss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              susp_req,
    input  logic              pll_locked,
    input  logic              cfg_semi_auto,
    input  logic              cfg_auto_resume,
    input  logic              cfg_stream_en,
    input  logic              vss_pulse,
    input  logic              hpd_irq_evt,
    input  logic              irq_clr,
    input  logic              cfg_irq_en,
    input  logic              cfg_hpd_irq_en,
    input  logic              cfg_pwm_active,
    output logic              pll_pd,
    output logic              tx_pd,
    output logic              rx_pd,
    output logic [MODE_W-1:0] ml_mode,
    output logic              video_tx_en,
    output logic              irq,
    output logic              pwm_oe
);
    logic     susp_s;
    pwr_dn_t  pd;
    ml_mode_e mode;

    lss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (susp_req),
        .q   (susp_s)
    );

    lss_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .susp_s          (susp_s),
        .pll_locked      (pll_locked),
        .cfg_semi_auto   (cfg_semi_auto),
        .cfg_auto_resume (cfg_auto_resume),
        .cfg_stream_en   (cfg_stream_en),
        .vss_pulse       (vss_pulse),
        .pd              (pd),
        .mode            (mode),
        .video_en        (video_tx_en)
    );

    lss_hpd_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (hpd_irq_evt),
        .clr    (irq_clr),
        .glb_en (cfg_irq_en),
        .hpd_en (cfg_hpd_irq_en),
        .irq    (irq)
    );

    assign pll_pd  = pd.pll;
    assign tx_pd   = pd.tx;
    assign rx_pd   = pd.rx;
    assign ml_mode = mode;
    assign pwm_oe  = cfg_pwm_active;

    // R9: the PWM enable ignores the power state
    a_r9_pwm_free: assert property (@(posedge clk) disable iff (rst)
        pll_pd |-> (pwm_oe == cfg_pwm_active));
endmodule

// File: tb/link_sleep_seq_tb.sv
`timescale 1ns/1ps
module link_sleep_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic susp_req = 0, pll_locked = 0, cfg_semi_auto = 0, cfg_auto_resume = 0;
    logic cfg_stream_en = 0, vss_pulse = 0, hpd_irq_evt = 0, irq_clr = 0;
    logic cfg_irq_en = 0, cfg_hpd_irq_en = 0, cfg_pwm_active = 0;
    logic pll_pd, tx_pd, rx_pd, video_tx_en, irq, pwm_oe;
    logic [1:0] ml_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    // reference model state
    int m_s1, m_s2, m_phase, m_lmode, m_stat;

    always #2 clk = ~clk;

    link_sleep_seq u_dut (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int p;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_phase = 1; m_lmode = 1; m_stat = 0;
        end else begin
            p = m_phase;
            case (m_phase)
                0: if (m_s2 == 0) p = 1;
                1: if (m_s2 != 0) p = 0;
                   else if (pll_locked) begin p = 2; m_lmode = cfg_semi_auto ? 2 : 1; end
                2: if (m_s2 != 0) p = 0;
                   else if (vss_pulse && (cfg_auto_resume || cfg_stream_en)) p = 3;
                default: if (m_s2 != 0) p = 0;
            endcase
            if (hpd_irq_evt) m_stat = 1;
            else if (irq_clr) m_stat = 0;
            m_s2 = m_s1;
            m_s1 = int'(susp_req);
            m_phase = p;
        end
    endtask

    task automatic compare();
        chk("R3 pll_pd", int'(pll_pd), int'(m_phase == 0));
        chk("R3 tx_pd",  int'(tx_pd),  int'(m_phase == 0));
        chk("R3 rx_pd",  int'(rx_pd),  int'(m_phase == 0));
        chk("R4 ml_mode", int'(ml_mode), (m_phase >= 2) ? m_lmode : 0);
        chk("R5/R6 video_tx_en", int'(video_tx_en), int'(m_phase == 3));
        chk("R7 irq", int'(irq), m_stat & int'(cfg_irq_en) & int'(cfg_hpd_irq_en));
        chk("R9 pwm_oe", int'(pwm_oe), int'(cfg_pwm_active));
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic pulse_vss();
        vss_pulse = 1; cyc(); vss_pulse = 0;
    endtask

    initial begin
        cyc(3);
        rst = 0;
        // R1 reset state
        chk("R1 pll_pd", int'(pll_pd), 0);
        chk("R1 ml_mode", int'(ml_mode), 0);
        chk("R1 video", int'(video_tx_en), 0);
        chk("R1 irq", int'(irq), 0);
        cyc(2);
        // lock in Normal, auto resume
        cfg_auto_resume = 1; cfg_pwm_active = 1;
        pll_locked = 1; cyc();
        chk("R4 normal", int'(ml_mode), 1);
        cfg_semi_auto = 1; cyc(2);
        chk("R4 mode held", int'(ml_mode), 1);
        pulse_vss();
        chk("R5 video up", int'(video_tx_en), 1);
        // interrupt enables
        cfg_irq_en = 1; hpd_irq_evt = 1; cyc(); hpd_irq_evt = 0;
        chk("R7 masked", int'(irq), 0);
        cfg_hpd_irq_en = 1; cyc();
        chk("R7 unmasked", int'(irq), 1);
        irq_clr = 1; cyc(); irq_clr = 0;
        chk("R7 cleared", int'(irq), 0);
        hpd_irq_evt = 1; irq_clr = 1; cyc(); hpd_irq_evt = 0; irq_clr = 0;
        chk("R7 event wins", int'(irq), 1);
        // suspend from video, latency through synchronizer
        susp_req = 1; cyc();
        chk("R2 edge1", int'(pll_pd), 0);
        cyc();
        chk("R2 edge2", int'(pll_pd), 0);
        cyc();
        chk("R2 edge3", int'(pll_pd), 1);
        chk("R10 video drop", int'(video_tx_en), 0);
        chk("R9 pwm in sleep", int'(pwm_oe), 1);
        pll_locked = 0;
        cyc(5);
        chk("R8 status kept", int'(irq), 1);
        cfg_pwm_active = 0; cyc();
        // release, lock later in Semi-Auto, software stream gating
        cfg_auto_resume = 0; cfg_stream_en = 0;
        susp_req = 0; cyc(6);
        chk("R4 off pre-lock", int'(ml_mode), 0);
        pll_locked = 1; cyc();
        chk("R4 semi", int'(ml_mode), 2);
        pulse_vss(); cyc(2);
        chk("R6 vss ignored", int'(video_tx_en), 0);
        cfg_stream_en = 1; cyc(3);
        chk("R6 needs vss", int'(video_tx_en), 0);
        pulse_vss();
        chk("R6 video up", int'(video_tx_en), 1);
        chk("R8 status survived", int'(irq), 1);
        irq_clr = 1; cyc(); irq_clr = 0;
        // suspend from PLL-wait
        susp_req = 1; cyc(4);
        susp_req = 0; pll_locked = 0; cyc(4);
        susp_req = 1; cyc(3);
        chk("R10 from wait", int'(pll_pd), 1);
        hpd_irq_evt = 1; cyc(); hpd_irq_evt = 0;
        susp_req = 0; cyc(4);
        chk("R8 event in sleep", int'(irq), 1);
        // suspend from link-up step
        cfg_semi_auto = 0; pll_locked = 1; cyc(2);
        chk("R4 normal again", int'(ml_mode), 1);
        susp_req = 1; cyc(3);
        chk("R10 from link", int'(pll_pd), 1);
        susp_req = 0; cyc(6);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule